// File: doc/BRIEF.md
# Monochrome Pattern Raster-Op Pixel Unit

This block is the per-pixel arithmetic stage of a two-dimensional block-transfer engine. For each pixel it receives a source pixel, the current destination pixel, one byte of monochrome pattern for the current row, the low destination address bits, the horizontal pixel counter, two pattern colors and a 32-bit control word. It returns either a new destination pixel or a flag that tells the memory side not to write.

A single pattern bit is picked from the row byte and expanded to a foreground or background color. That color, the source and the destination then feed an 8-bit ternary raster operation. Pixels can be one, two or three bytes wide and travel in a 32-bit word. The stage can treat clear pattern bits as transparent, and it can force the pattern row to all zeros. The address generator fetches the pattern row and the pixels. It gives one pixel per cycle with a valid strobe and takes the result one cycle later.

Top module: `patRopUnit`

## Requirements
- R1: `outValid` equals `inValid` of the previous clock. `outPix` and `outSkip` load only in a cycle where `inValid` is high and hold their value otherwise. Reset (active-low `rstN`) clears `outValid`, `outPix` and `outSkip` to zero.
- R2: For each bit i inside the pixel width, the result bit is `ctrl[7:0]` indexed by {P[i], S[i], D[i]}, so the index is 4·P + 2·S + D. P is the pattern operand, S the source and D the destination.
- R3: The selected pattern bit is `patRow[(dstBaseLow + xCount) mod 8]`.
- R4: When `ctrl[18]` is set, the pattern operand is `patFg` if the selected pattern bit is 1 and `patBg` if it is 0, masked to 8·(bytes per pixel) bits. When `ctrl[18]` is clear, the pattern operand is zero.
- R5: When `ctrl[19]` is set, the pattern row is treated as all zeros, so every pixel selects the background color.
- R6: When `ctrl[17]` and `ctrl[18]` are both set and the selected pattern bit is 0, `outSkip` is 1 and `outPix` equals `dstPix` unchanged. In every other case `outSkip` is 0.
- R7: When `ctrl[7:4]` equals `ctrl[3:0]`, the result does not depend on the pattern colors or the pattern row, except through the skip rule of R6.
- R8: With `bytesPerPix` = 3, bits 23:0 carry the raster result and bits 31:24 equal `dstPix[31:24]`.
- R9: With `bytesPerPix` = 1 or 2, the bits of `outPix` above the pixel width are zero. A `bytesPerPix` code of 0 is treated as 1 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Pixel operands valid this cycle |
| ctrl | input | 32 | Control word: raster op in 7:0, transparency 17, pattern enable 18, solid 19 |
| srcPix | input | 32 | Source pixel, right-aligned |
| dstPix | input | 32 | Current destination pixel word |
| patRow | input | 8 | Monochrome pattern byte for the current row |
| dstBaseLow | input | 3 | Low three bits of the destination base address |
| xCount | input | 16 | Horizontal pixel counter within the row |
| patFg | input | 32 | Pattern foreground color |
| patBg | input | 32 | Pattern background color |
| bytesPerPix | input | 2 | Pixel size in bytes (1, 2, 3; 0 means 1) |
| outValid | output | 1 | Result valid |
| outPix | output | 32 | New destination pixel word |
| outSkip | output | 1 | Destination write must be suppressed |

## Verification
The bench sweeps `xCount` against every `dstBaseLow` with a single set bit in the row. A bit-index error, for example forgetting the base offset or indexing from the MSB, paints the foreground at the wrong column. Random raster codes are run with all operands random, so any swap of the P, S and D index positions corrupts results for most codes. Equal-nibble codes are paired with changing pattern colors to show the pattern has no effect. Transparency, solid mode and the 24-bit top byte are each exercised. A design that wrote on a clear bit, left the row live in solid mode, or zeroed the top destination byte would show a wrong `outSkip` or wrong upper bits. Idle cycles with moving inputs show whether the output registers hold.

// File: rtl/patRopPkg.sv
package patRopPkg;
  localparam int CTRL_W = 32;
  localparam int ROP_LO = 0;
  localparam int MASK_BIT = 17;
  localparam int PAT_EN_BIT = 18;
  localparam int SOLID_BIT = 19;

  typedef struct packed {
    logic       load;
    logic       patEn;
    logic       patBit;
    logic       skip;
    logic       fallback;
    logic [1:0] pixBytes;
  } ropStrobes_t;
endpackage

// File: rtl/patRopCtl.sv
module patRopCtl
  import patRopPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ROW_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [CTRL_W-1:0]        ctrl,
  input  logic [ROW_W-1:0]         patRow,
  input  logic [$clog2(ROW_W)-1:0] dstBaseLow,
  input  logic [CNT_W-1:0]         xCount,
  input  logic [1:0]               bytesPerPix,
  output ropStrobes_t              strobes,
  output logic                     outValid
);
  localparam int IDX_W = $clog2(ROW_W);

  logic [ROW_W-1:0] rowEff;
  logic [IDX_W-1:0] bitIdx;
  logic [7:0]       ropCode;
  logic             selBit;

  assign ropCode = ctrl[ROP_LO +: 8];
  assign rowEff  = ctrl[SOLID_BIT] ? '0 : patRow;
  assign bitIdx  = dstBaseLow + xCount[IDX_W-1:0];
  assign selBit  = rowEff[bitIdx];

  always_comb begin
    strobes          = '0;
    strobes.load     = inValid;
    strobes.patEn    = ctrl[PAT_EN_BIT];
    strobes.patBit   = selBit;
    strobes.skip     = ctrl[PAT_EN_BIT] & ctrl[MASK_BIT] & ~selBit;
    strobes.fallback = (ropCode[7:4] == ropCode[3:0]);
    strobes.pixBytes = (bytesPerPix == 2'd0) ? 2'd1 : bytesPerPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/patRopData.sv
module patRopData
  import patRopPkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ropStrobes_t      strobes,
  input  logic [7:0]       ropCode,
  input  logic [PIX_W-1:0] srcPix,
  input  logic [PIX_W-1:0] dstPix,
  input  logic [PIX_W-1:0] patFg,
  input  logic [PIX_W-1:0] patBg,
  output logic [PIX_W-1:0] outPix,
  output logic             outSkip
);
  localparam int LANES = PIX_W / 8;

  logic [LANES-1:0] laneOn;
  logic [PIX_W-1:0] widthMask;
  logic [PIX_W-1:0] patOp;
  logic [PIX_W-1:0] triRes;
  logic [PIX_W-1:0] srcOnlyRes;
  logic [PIX_W-1:0] ropRes;
  logic [PIX_W-1:0] nextPix;
  logic             keepUpper;

  assign keepUpper = (strobes.pixBytes == 2'd3);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign laneOn[b] = (32'(b) < {30'd0, strobes.pixBytes});
    assign widthMask[b*8 +: 8] = {8{laneOn[b]}};
    assign nextPix[b*8 +: 8] = laneOn[b] ? ropRes[b*8 +: 8]
                             : (keepUpper ? dstPix[b*8 +: 8] : 8'd0);
  end

  assign patOp = strobes.patEn
               ? ((strobes.patBit ? patFg : patBg) & widthMask)
               : '0;

  for (genvar i = 0; i < PIX_W; i++) begin : g_bit
    assign triRes[i]     = ropCode[{patOp[i], srcPix[i], dstPix[i]}];
    assign srcOnlyRes[i] = ropCode[{1'b0, srcPix[i], dstPix[i]}];
  end

  assign ropRes = strobes.fallback ? srcOnlyRes : triRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPix  <= '0;
      outSkip <= 1'b0;
    end else if (strobes.load) begin
      outPix  <= strobes.skip ? dstPix : nextPix;
      outSkip <= strobes.skip;
    end
  end
endmodule

// File: rtl/patRopUnit.sv
module patRopUnit
  import patRopPkg::*;
#(
  parameter int PIX_W = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       ctrl,
  input  logic [PIX_W-1:0]  srcPix,
  input  logic [PIX_W-1:0]  dstPix,
  input  logic [7:0]        patRow,
  input  logic [2:0]        dstBaseLow,
  input  logic [CNT_W-1:0]  xCount,
  input  logic [PIX_W-1:0]  patFg,
  input  logic [PIX_W-1:0]  patBg,
  input  logic [1:0]        bytesPerPix,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPix,
  output logic              outSkip
);
  ropStrobes_t strobes;

  patRopCtl #(.CNT_W(CNT_W), .ROW_W(8)) uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl),
    .patRow(patRow), .dstBaseLow(dstBaseLow), .xCount(xCount),
    .bytesPerPix(bytesPerPix), .strobes(strobes), .outValid(outValid)
  );

  patRopData #(.PIX_W(PIX_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ropCode(ctrl[7:0]),
    .srcPix(srcPix), .dstPix(dstPix), .patFg(patFg), .patBg(patBg),
    .outPix(outPix), .outSkip(outSkip)
  );
endmodule

// File: rtl/patRopUnit_chk.sv
module patRopUnit_chk #(
  parameter int PIX_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [31:0]      ctrl,
  input logic [PIX_W-1:0] dstPix,
  input logic [1:0]       bytesPerPix,
  input logic             outValid,
  input logic [PIX_W-1:0] outPix,
  input logic             outSkip
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outPix) && $stable(outSkip)));
  p_skip_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !(ctrl[17] && ctrl[18]) |=> !outSkip);
  p_skip_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (!outSkip || outPix == $past(dstPix)));
  p_top_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && bytesPerPix == 2'd3 |=> outPix[31:24] == $past(dstPix[31:24]));
  p_narrow_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && bytesPerPix != 2'd3 && !(ctrl[17] && ctrl[18]) |=> outPix[31:16] == 16'd0);
endmodule

bind patRopUnit patRopUnit_chk #(.PIX_W(PIX_W)) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .dstPix(dstPix),
  .bytesPerPix(bytesPerPix), .outValid(outValid), .outPix(outPix),
  .outSkip(outSkip)
);

// File: tb/patRopUnit_test.sv
module patRopUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] ctrl = '0, srcPix = '0, dstPix = '0, patFg = '0, patBg = '0;
  logic [7:0]  patRow = '0;
  logic [2:0]  dstBaseLow = '0;
  logic [15:0] xCount = '0;
  logic [1:0]  bytesPerPix = 2'd1;
  logic        outValid, outSkip;
  logic [31:0] outPix;

  int total = 0, bad = 0;
  bit expValid = 0, expSkip = 0;
  logic [31:0] expPix = '0;
  string prevTag = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  patRopUnit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .srcPix(srcPix),
    .dstPix(dstPix), .patRow(patRow), .dstBaseLow(dstBaseLow), .xCount(xCount),
    .patFg(patFg), .patBg(patBg), .bytesPerPix(bytesPerPix),
    .outValid(outValid), .outPix(outPix), .outSkip(outSkip)
  );

  function automatic logic [31:0] model(input logic [31:0] c, s, d, fg, bg,
      input logic [7:0] row, input int base, input int x, input int bpp,
      output bit skip);
    int nb = (bpp == 0) ? 1 : bpp;
    int idx = (base + x) % 8;
    bit pb = c[19] ? 1'b0 : row[idx];
    logic [31:0] p, r;
    skip = c[18] && c[17] && !pb;
    if (skip) return d;
    p = c[18] ? (pb ? fg : bg) : 32'd0;
    r = '0;
    for (int i = 0; i < 8 * nb; i++) r[i] = c[p[i] * 4 + s[i] * 2 + d[i]];
    if (nb == 3) r[31:24] = d[31:24];
    return r;
  endfunction

  task automatic compare();
    total++;
    if (outValid !== expValid || (expValid && (outPix !== expPix || outSkip !== expSkip))
        || (!expValid && (outPix !== expPix || outSkip !== expSkip))) begin
      bad++;
      $display("FAIL %s: got v=%0b pix=%h skip=%0b, expected v=%0b pix=%h skip=%0b",
               prevTag, outValid, outPix, outSkip, expValid, expPix, expSkip);
    end
  endtask

  task automatic drive(input string tag, input logic [31:0] c, s, d, fg, bg,
      input logic [7:0] row, input int base, input int x, input int bpp);
    bit sk;
    @(negedge clk);
    compare();
    ctrl = c; srcPix = s; dstPix = d; patFg = fg; patBg = bg; patRow = row;
    dstBaseLow = 3'(base); xCount = 16'(x); bytesPerPix = 2'(bpp); inValid = 1'b1;
    expPix = model(c, s, d, fg, bg, row, base, x, bpp, sk);
    expSkip = sk; expValid = 1'b1; prevTag = tag;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    compare();
    inValid = 1'b0; ctrl = $urandom; srcPix = $urandom; dstPix = $urandom;
    patFg = $urandom; patBg = $urandom; patRow = 8'($urandom);
    expValid = 1'b0; prevTag = tag;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    compare();
    rstN = 1'b1;
    prevTag = "R1";
    // R3: pattern bit index sweep, rop 0xF0 copies P
    for (int b = 0; b < 8; b++)
      for (int x = 0; x < 10; x++)
        drive("R3", 32'h0004_00F0, $urandom, $urandom, 32'hFFFF_FFFF, 32'h0,
              8'h01 << (x % 8), b, x + 16 * b, 3);
    // R4: foreground/background selection and disabled pattern
    for (int k = 0; k < 20; k++)
      drive("R4", 32'h0004_00F0, $urandom, $urandom, $urandom, $urandom,
            8'($urandom), k % 8, $urandom % 100, 1 + k % 3);
    for (int k = 0; k < 10; k++)
      drive("R4", 32'h0000_00F0, $urandom, $urandom, $urandom, $urandom,
            8'hFF, 0, k, 3);
    // R1: idle cycles must hold outputs
    repeat (4) idle("R1");
    // R2: random raster ops with full ternary
    for (int k = 0; k < 200; k++)
      drive("R2", {12'h0, 4'h4, 8'h0, 8'($urandom)}, $urandom, $urandom,
            $urandom, $urandom, 8'($urandom), $urandom % 8, $urandom % 64, 1 + k % 3);
    // R5: solid mode always picks background
    for (int k = 0; k < 16; k++)
      drive("R5", 32'h000C_00F0, $urandom, $urandom, 32'hFFFF_FFFF, $urandom,
            8'hFF, k % 8, k, 3);
    // R6: transparency skip
    for (int k = 0; k < 32; k++)
      drive("R6", {12'h0, 4'h6, 8'h0, 8'($urandom)}, $urandom, $urandom,
            $urandom, $urandom, 8'($urandom), k % 8, k, 1 + k % 3);
    drive("R6", 32'h000E_0033, $urandom, 32'h1234_5678, 0, 0, 8'hFF, 0, 0, 2);
    // R7: equal-nibble codes ignore pattern colors
    for (int k = 0; k < 40; k++) begin
      logic [3:0] n = 4'($urandom);
      drive("R7", {12'h0, 4'h4, 8'h0, n, n}, 32'hA5A5_3C3C, 32'h0F0F_6969,
            $urandom, $urandom, 8'($urandom), k % 8, k, 3);
    end
    // R8: 24-bit keeps destination top byte
    for (int k = 0; k < 12; k++)
      drive("R8", 32'h0004_00FF, $urandom, $urandom, $urandom, $urandom,
            8'($urandom), 0, k, 3);
    // R9: narrow pixels and code 0
    for (int k = 0; k < 24; k++)
      drive("R9", 32'h0004_00FF, $urandom, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
            32'hFFFF_FFFF, 8'($urandom), 0, k, k % 3);
    repeat (3) idle("R1");
    @(negedge clk);
    compare();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule